// File: doc/BRIEF.md
# Digit-Serial Adder/Subtractor Cell

The cell adds or subtracts two operands that arrive one digit per clock, with the least significant digit first. Each digit is `DIGIT_W` bits wide. Setting `DIGIT_W` to 1 gives a bit-serial adder. Setting it to the full operand width gives an ordinary parallel adder.

Within one digit, a chain of `DIGIT_W` full adders produces the result digit. A single carry flip-flop passes the top carry into the next digit. Subtraction uses two's complement: the second operand's digit is inverted, and the word's initial carry is 1 instead of 0.

A `word_start` pulse marks the first digit of every word. In that cycle the carry-in is forced to the initial value for the requested operation. The operation sampled then holds for the rest of the word, whatever `sub_mode` does later in the word. The result digit is combinational, so it appears in the same cycle as its input digits.

The cell is meant as a building block in shift-add networks that multiply by constants.

Top module: `digit_serial_addsub`

## Requirements
- R1: After reset and before any word start, the cell adds with carry-in 0: `sum_dig = (a_dig + b_dig) mod 2^DIGIT_W`, whatever the level of `sub_mode`.
- R2: In a cycle with `word_start`=1 and `sub_mode`=0, `sum_dig = (a_dig + b_dig) mod 2^DIGIT_W`. No carry left from earlier digits is added.
- R3: In a cycle with `word_start`=1 and `sub_mode`=1, `sum_dig = (a_dig + ~b_dig + 1) mod 2^DIGIT_W`, which equals `a_dig - b_dig`.
- R4: In a cycle with `word_start`=0, the carry-in equals the carry out of the top bit of the previous cycle's digit sum.
- R5: The operation chosen at `word_start` applies to every digit of the word. A change of `sub_mode` while `word_start`=0 has no effect.
- R6: A `word_start` arriving directly after an unfinished word discards the pending carry and the previous operation.
- R7: `sum_dig` follows a change of `a_dig` or `b_dig` within the same cycle, with no clock edge in between.
- R8: Over a word of n digits, the collected result digits equal `(A + B)` or `(A - B)` mod `2^(n*DIGIT_W)`.
- R9: Pulling `rst_n` low at any time clears the pending carry and returns the cell to add mode. This holds even in the middle of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It takes effect at once and is released synchronously inside the cell. |
| word_start | input | 1 | Marks the first (least significant) digit of a word |
| sub_mode | input | 1 | 0 selects add, 1 selects subtract. Sampled when `word_start`=1. |
| a_dig | input | DIGIT_W | Digit of the first operand |
| b_dig | input | DIGIT_W | Digit of the second operand (the subtrahend) |
| sum_dig | output | DIGIT_W | Result digit, valid in the same cycle as its inputs |

## Verification
The bench drives multi-digit words in which a carry must ripple across every digit boundary, and a borrow chain that turns a small difference into all-ones digits. A cell with a broken carry register would leave the upper digits off by one.

It toggles `sub_mode` in the middle of words. A cell that reads the mode live instead of holding it would flip the operation partway through.

It issues back-to-back word starts after a digit that produced a carry. A cell that failed to re-initialise the carry would leak that carry into the new word.

It also pulls reset low in the middle of a subtract word. A cell that kept its state across reset would then go on subtracting or add a stale carry.

// File: rtl/dsas_pkg.sv
package dsas_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } dsas_op_e;

  // Carry-in that starts a word: two's complement needs +1 for subtraction.
  function automatic logic word_carry_init(dsas_op_e op);
    return (op == OP_SUB);
  endfunction

endpackage

// File: rtl/dsas_rst_sync.sv
module dsas_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_core_n = sync_q[STAGES-1];

endmodule

// File: rtl/dsas_full_adder.sv
module dsas_full_adder (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);

  always_comb begin
    s  = x ^ y ^ ci;
    co = (x & y) | (ci & (x ^ y));
  end

endmodule

// File: rtl/dsas_operand_cond.sv
module dsas_operand_cond #(
  parameter int DIGIT_W = 4
) (
  input  logic               invert,
  input  logic [DIGIT_W-1:0] b_in,
  output logic [DIGIT_W-1:0] b_out
);

  // One inverter per bit, gated by the operation.
  for (genvar g = 0; g < DIGIT_W; g++) begin : g_inv
    assign b_out[g] = b_in[g] ^ invert;
  end

endmodule

// File: rtl/dsas_ripple.sv
module dsas_ripple #(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] a_in,
  input  logic [DIGIT_W-1:0] b_in,
  input  logic               c_in,
  output logic [DIGIT_W-1:0] s_out,
  output logic               c_out
);

  logic [DIGIT_W:0] chain;

  assign chain[0] = c_in;

  for (genvar g = 0; g < DIGIT_W; g++) begin : g_fa
    dsas_full_adder u_fa (
      .x  (a_in[g]),
      .y  (b_in[g]),
      .ci (chain[g]),
      .s  (s_out[g]),
      .co (chain[g+1])
    );
  end

  assign c_out = chain[DIGIT_W];

endmodule

// File: rtl/dsas_carry_ctrl.sv
module dsas_carry_ctrl
  import dsas_pkg::*;
(
  input  logic clk,
  input  logic rst_core_n,
  input  logic word_start,
  input  logic sub_mode,
  input  logic carry_top,
  output logic carry_in,
  output logic invert
);

  dsas_op_e op_q, op_d, op_eff;
  logic     carry_q, carry_d;

  // Next-state logic: a word start overrides the stored carry and operation.
  always_comb begin
    if (word_start) begin
      op_eff   = sub_mode ? OP_SUB : OP_ADD;
      carry_in = word_carry_init(op_eff);
    end else begin
      op_eff   = op_q;
      carry_in = carry_q;
    end
    invert  = (op_eff == OP_SUB);
    op_d    = op_eff;
    carry_d = carry_top;
  end

  // State registers: the single inter-digit carry and the held operation.
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      carry_q <= 1'b0;
      op_q    <= OP_ADD;
    end else begin
      carry_q <= carry_d;
      op_q    <= op_d;
    end
  end

endmodule

// File: rtl/digit_serial_addsub.sv
module digit_serial_addsub #(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_start,
  input  logic               sub_mode,
  input  logic [DIGIT_W-1:0] a_dig,
  input  logic [DIGIT_W-1:0] b_dig,
  output logic [DIGIT_W-1:0] sum_dig
);

  localparam int RST_STAGES = 2;

  logic               rst_core_n;
  logic               carry_in;
  logic               carry_top;
  logic               invert;
  logic [DIGIT_W-1:0] b_cond;

  dsas_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  dsas_carry_ctrl u_ctrl (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .word_start (word_start),
    .sub_mode   (sub_mode),
    .carry_top  (carry_top),
    .carry_in   (carry_in),
    .invert     (invert)
  );

  dsas_operand_cond #(.DIGIT_W(DIGIT_W)) u_cond (
    .invert (invert),
    .b_in   (b_dig),
    .b_out  (b_cond)
  );

  dsas_ripple #(.DIGIT_W(DIGIT_W)) u_add (
    .a_in  (a_dig),
    .b_in  (b_cond),
    .c_in  (carry_in),
    .s_out (sum_dig),
    .c_out (carry_top)
  );

endmodule

// File: rtl/digit_serial_addsub_chk.sv
module digit_serial_addsub_chk #(
  parameter int DIGIT_W = 4
) (
  input logic               clk,
  input logic               rst_core_n,
  input logic               word_start,
  input logic               sub_mode,
  input logic [DIGIT_W-1:0] a_dig,
  input logic [DIGIT_W-1:0] b_dig,
  input logic [DIGIT_W-1:0] sum_dig
);

  logic             m_carry, m_sub;
  logic             e_sub, e_cin;
  logic [DIGIT_W:0] e_full;

  // Arithmetic reference built from the ports only.
  always_comb begin
    e_sub  = word_start ? sub_mode : m_sub;
    e_cin  = word_start ? sub_mode : m_carry;
    e_full = {1'b0, a_dig} + {1'b0, (e_sub ? ~b_dig : b_dig)} + {{DIGIT_W{1'b0}}, e_cin};
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      m_carry <= 1'b0;
      m_sub   <= 1'b0;
    end else begin
      m_carry <= e_full[DIGIT_W];
      m_sub   <= e_sub;
    end
  end

  a_r2_add_start: assert property (@(posedge clk) disable iff (!rst_core_n)
    (word_start && !sub_mode) |-> (sum_dig == DIGIT_W'(a_dig + b_dig)));

  a_r3_sub_start: assert property (@(posedge clk) disable iff (!rst_core_n)
    (word_start && sub_mode) |-> (sum_dig == DIGIT_W'(a_dig - b_dig)));

  a_r4_carry_chain: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!word_start && !m_sub) |-> (sum_dig == e_full[DIGIT_W-1:0]));

  a_r5_mode_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!word_start && m_sub) |-> (sum_dig == e_full[DIGIT_W-1:0]));

endmodule

bind digit_serial_addsub digit_serial_addsub_chk #(.DIGIT_W(DIGIT_W)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .word_start (word_start),
  .sub_mode   (sub_mode),
  .a_dig      (a_dig),
  .b_dig      (b_dig),
  .sum_dig    (sum_dig)
);

// File: tb/test_digit_serial_addsub.sv
`timescale 1ns/100ps
module test_digit_serial_addsub;

  localparam int W = 4;
  localparam int NV = 24;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         word_start, sub_mode;
  logic [W-1:0] a_dig, b_dig;
  logic [W-1:0] sum_dig;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  digit_serial_addsub #(.DIGIT_W(W)) i_digit_serial_addsub (
    .clk(clk), .rst_n(rst_n), .word_start(word_start), .sub_mode(sub_mode),
    .a_dig(a_dig), .b_dig(b_dig), .sum_dig(sum_dig)
  );

  // Entry: {req, ws, sub, a, b, expected}
  localparam logic [17:0] VEC [NV] = '{
    // R8 / R2 / R4: 0x2F9 + 0x1A8 = 0x4A1, carries ripple twice
    {4'd2, 1'b1, 1'b0, 4'h9, 4'h8, 4'h1},
    {4'd4, 1'b0, 1'b0, 4'hF, 4'hA, 4'hA},
    {4'd8, 1'b0, 1'b0, 4'h2, 4'h1, 4'h4},
    // R8 / R3: 0x300 - 0x001 = 0x2FF, borrow chain
    {4'd3, 1'b1, 1'b1, 4'h0, 4'h1, 4'hF},
    {4'd4, 1'b0, 1'b1, 4'h0, 4'h0, 4'hF},
    {4'd8, 1'b0, 1'b1, 4'h3, 4'h0, 4'h2},
    // R5: 0x55 - 0x23 = 0x32, sub_mode dropped mid-word
    {4'd3, 1'b1, 1'b1, 4'h5, 4'h3, 4'h2},
    {4'd5, 1'b0, 1'b0, 4'h5, 4'h2, 4'h3},
    // R5: 0x0F + 0x01 = 0x10, sub_mode raised mid-word
    {4'd2, 1'b1, 1'b0, 4'hF, 4'h1, 4'h0},
    {4'd5, 1'b0, 1'b1, 4'h0, 4'h0, 4'h1},
    // R6: restarts after a carry-producing digit
    {4'd2, 1'b1, 1'b0, 4'hF, 4'hF, 4'hE},
    {4'd6, 1'b1, 1'b0, 4'h1, 4'h1, 4'h2},
    {4'd3, 1'b1, 1'b1, 4'h0, 4'h0, 4'h0},
    {4'd6, 1'b1, 1'b0, 4'h0, 4'h0, 4'h0},
    // R8: 0x10 - 0x01 = 0x0F
    {4'd3, 1'b1, 1'b1, 4'h0, 4'h1, 4'hF},
    {4'd8, 1'b0, 1'b1, 4'h1, 4'h0, 4'h0},
    // R8: 0xFFFF + 0x0001 = 0x0000 over four digits
    {4'd2, 1'b1, 1'b0, 4'hF, 4'h1, 4'h0},
    {4'd4, 1'b0, 1'b0, 4'hF, 4'h0, 4'h0},
    {4'd4, 1'b0, 1'b0, 4'hF, 4'h0, 4'h0},
    {4'd8, 1'b0, 1'b0, 4'hF, 4'h0, 4'h0},
    // R8: 0x1234 - 0x1234 = 0x0000
    {4'd3, 1'b1, 1'b1, 4'h4, 4'h4, 4'h0},
    {4'd4, 1'b0, 1'b1, 4'h3, 4'h3, 4'h0},
    {4'd4, 1'b0, 1'b1, 4'h2, 4'h2, 4'h0},
    {4'd8, 1'b0, 1'b1, 4'h1, 4'h1, 4'h0}
  };

  task automatic check(input string req, input logic [W-1:0] exp);
    n_cmp++;
    if (sum_dig !== exp) begin
      n_bad++;
      $display("FAIL %s: sum_dig actual %h expected %h", req, sum_dig, exp);
    end
  endtask

  task automatic drive(input logic ws, input logic sb, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    word_start = ws; sub_mode = sb; a_dig = a; b_dig = b;
    #1;
  endtask

  initial begin
    rst_n = 1'b0; word_start = 1'b0; sub_mode = 1'b0; a_dig = '0; b_dig = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state adds with zero carry even though sub_mode is high
    drive(1'b0, 1'b1, 4'h3, 4'h4);
    check("R1", 4'h7);
    drive(1'b0, 1'b1, 4'h9, 4'h9);
    check("R1", 4'h2);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][13], VEC[i][12], VEC[i][11:8], VEC[i][7:4]);
      check($sformatf("R%0d", VEC[i][17:14]), VEC[i][3:0]);
    end

    // R7: output follows the input digit inside the same cycle
    drive(1'b1, 1'b0, 4'h1, 4'h2);
    check("R7", 4'h3);
    a_dig = 4'h6;
    #0.5;
    check("R7", 4'h8);
    b_dig = 4'h9;
    #0.5;
    check("R7", 4'hF);

    // R9: reset in the middle of a subtract word with a pending carry
    drive(1'b1, 1'b1, 4'h5, 4'h3);
    check("R9", 4'h2);
    rst_n = 1'b0;
    #0.5;
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 4'h0, 4'h0);
    drive(1'b0, 1'b0, 4'h0, 4'h0);
    drive(1'b0, 1'b0, 4'h0, 4'h0);
    drive(1'b0, 1'b0, 4'h5, 4'h3);
    check("R9", 4'h8);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule